// File: doc/BRIEF.md
# USB Full-Speed Link State Monitor

This block follows the condition of a full-speed USB link from the device side. It takes the already decoded line condition (single-ended zero, idle J, or anything else), the VBUS sense input, a start-of-frame strobe from the packet engine and a 1 µs timing tick. From these it keeps a two-bit link state and a host-lost flag. It also produces one-cycle event pulses that an interrupt block or a control engine can latch.

Dwell times are measured in ticks of the microsecond strobe, so the block is independent of the core clock frequency. A detected bus reset also gives a one-cycle pulse that the address register uses to return the device address to zero.

Top module: `usb_link_mon`

## Requirements
- R1: Out of reset `link_state_o` is 0, `host_lost_o` is 0 and every pulse output is 0. State codes are 0 = disconnected, 1 = bus reset, 2 = suspended and 3 = active.
- R2: While `enable_i` is low, the state is forced to 0 from the next cycle, `host_lost_o` is 0 from the next cycle, and no event pulse is raised, whatever the line does.
- R3: When enabled and VBUS drops, the state becomes 0 one cycle later. `ev_disconnect_o` pulses once, and only if the state was not already 0.
- R4: When enabled with VBUS present and no bus reset detected, a disconnected link moves to active (3) one cycle later, with no pulse.
- R5: SE0 seen on more than `RESET_US` consecutive ticks moves the state to 1. `ev_reset_o` and `addr_clr_o` pulse together on entry. The state returns to 3 two cycles after SE0 ends.
- R6: Any cycle without SE0 restarts the SE0 dwell count, so SE0 held for `RESET_US` ticks or fewer never causes a reset.
- R7: From the active state, idle J on more than `SUSPEND_US` consecutive ticks moves the state to 2 and pulses `ev_suspend_o` once.
- R8: In the suspended state, any line condition other than J returns the state to 3 one cycle later and pulses `ev_resume_o` once.
- R9: While active, `SOF_GAP_US` ticks without `sof_i` set `host_lost_o` and pulse `ev_host_lost_o` once. `sof_i`, or leaving the active state, clears the flag and restarts the gap count.
- R10: Each event output is high for single cycles only, on entry to its condition, never while the condition persists. At most one of the four state-change pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Monitor enable; low holds state 0 |
| tick_us_i | input | 1 | One-cycle strobe every microsecond |
| vbus_i | input | 1 | VBUS present |
| line_se0_i | input | 1 | Line currently at SE0 |
| line_j_i | input | 1 | Line currently idle (J); ignored while SE0 is high |
| sof_i | input | 1 | Start-of-frame received strobe |
| link_state_o | output | 2 | Link state code |
| host_lost_o | output | 1 | No SOF within the gap window while active |
| ev_disconnect_o | output | 1 | Pulse on entry to disconnected |
| ev_reset_o | output | 1 | Pulse on bus reset detection |
| ev_suspend_o | output | 1 | Pulse on entry to suspended |
| ev_resume_o | output | 1 | Pulse on return from suspended |
| ev_host_lost_o | output | 1 | Pulse when host-lost is raised |
| addr_clr_o | output | 1 | Pulse to zero the device address |

## Verification
On every cycle, the assertions check the bounds of the dwell counters, that a pulse marks a real change of state or flag, the exclusivity of the state pulses, and that dropping enable or VBUS forces the disconnected state. Some behaviour shows only across a scenario: the exact dwell lengths at the threshold boundaries, the restart of the counts when the line changes, and sparse-tick timing. The bench covers these with a behavioural model compared on every clock, plus directed pulse counts.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;
  typedef enum logic [1:0] {
    LINK_DISC    = 2'd0,
    LINK_RESET   = 2'd1,
    LINK_SUSPEND = 2'd2,
    LINK_ACTIVE  = 2'd3
  } link_state_e;

  typedef struct packed {
    logic disc;
    logic rst;
    logic susp;
    logic resume;
  } link_ev_t;
endpackage

// File: rtl/usb_link_dwell.sv
module usb_link_dwell #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cond_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!cond_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  // hit means the condition held on more than LIMIT ticks
  assign hit_o = (cnt_q == TOP);

  // R6
  dwell_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);
  // R6
  dwell_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> !hit_o);
endmodule

// File: rtl/usb_link_sof_watch.sv
module usb_link_sof_watch #(
  parameter int unsigned GAP = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic sof_i,
  output logic lost_o,
  output logic lost_ev_o
);
  localparam int unsigned CW = $clog2(GAP + 1);
  localparam logic [CW-1:0] GAP_C  = CW'(GAP);
  localparam logic [CW-1:0] LAST_C = CW'(GAP - 1);

  logic [CW-1:0] cnt_q;
  logic          lost_q, ev_q;
  logic          expire;

  assign expire = tick_i && (cnt_q == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
      ev_q   <= 1'b0;
    end else if (sof_i || !active_i) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      ev_q <= 1'b0;
      if (tick_i && cnt_q != GAP_C) cnt_q <= cnt_q + 1'b1;
      if (expire) begin
        lost_q <= 1'b1;
        ev_q   <= 1'b1;
      end
    end
  end

  assign lost_o    = lost_q;
  assign lost_ev_o = ev_q;

  // R9
  lost_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_ev_o |-> lost_o && !$past(lost_o));
  // R9
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !lost_o);
endmodule

// File: rtl/usb_link_fsm.sv
module usb_link_fsm
  import usb_link_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        vbus_i,
  input  logic        se0_i,
  input  logic        idle_i,
  input  logic        se0_hit_i,
  input  logic        idle_hit_i,
  output link_state_e state_o,
  output link_ev_t    ev_o
);
  link_state_e state_q, state_d;
  link_ev_t    ev_q, ev_d;

  always_comb begin
    state_d = state_q;
    ev_d    = '0;
    if (!enable_i) begin
      state_d = LINK_DISC;
    end else if (!vbus_i) begin
      state_d = LINK_DISC;
      ev_d.disc = (state_q != LINK_DISC);
    end else if (se0_hit_i) begin
      state_d = LINK_RESET;
      ev_d.rst = (state_q != LINK_RESET);
    end else begin
      unique case (state_q)
        LINK_DISC:  state_d = LINK_ACTIVE;
        LINK_RESET: if (!se0_i) state_d = LINK_ACTIVE;
        LINK_ACTIVE: if (idle_hit_i) begin
          state_d   = LINK_SUSPEND;
          ev_d.susp = 1'b1;
        end
        LINK_SUSPEND: if (!idle_i) begin
          state_d     = LINK_ACTIVE;
          ev_d.resume = 1'b1;
        end
        default: state_d = LINK_DISC;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINK_DISC;
      ev_q    <= '0;
    end else begin
      state_q <= state_d;
      ev_q    <= ev_d;
    end
  end

  assign state_o = state_q;
  assign ev_o    = ev_q;

  // R2
  disable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> state_q == LINK_DISC && ev_q == '0);
  // R3
  vbus_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !vbus_i) |=> state_q == LINK_DISC);
  // R5
  reset_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q.rst |-> state_q == LINK_RESET && $past(state_q) != LINK_RESET);
  // R7
  suspend_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q.susp |-> state_q == LINK_SUSPEND && $past(state_q) == LINK_ACTIVE);
  // R8
  resume_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q.resume |-> state_q == LINK_ACTIVE && $past(state_q) == LINK_SUSPEND);
  // R10
  ev_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_q));
endmodule

// File: rtl/usb_link_mon.sv
module usb_link_mon
  import usb_link_pkg::*;
#(
  parameter int unsigned RESET_US   = 3,
  parameter int unsigned SUSPEND_US = 3000,
  parameter int unsigned SOF_GAP_US = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       tick_us_i,
  input  logic       vbus_i,
  input  logic       line_se0_i,
  input  logic       line_j_i,
  input  logic       sof_i,
  output logic [1:0] link_state_o,
  output logic       host_lost_o,
  output logic       ev_disconnect_o,
  output logic       ev_reset_o,
  output logic       ev_suspend_o,
  output logic       ev_resume_o,
  output logic       ev_host_lost_o,
  output logic       addr_clr_o
);
  logic        live, idle, se0_run, idle_run, se0_hit, idle_hit, sof_active;
  link_state_e state;
  link_ev_t    ev;

  assign live     = enable_i && vbus_i;
  assign idle     = line_j_i && !line_se0_i;
  assign se0_run  = live && line_se0_i;
  assign idle_run = live && idle;

  usb_link_dwell #(.LIMIT(RESET_US)) u_se0_dwell (
    .clk_i, .rst_ni, .cond_i(se0_run), .tick_i(tick_us_i), .hit_o(se0_hit)
  );

  usb_link_dwell #(.LIMIT(SUSPEND_US)) u_idle_dwell (
    .clk_i, .rst_ni, .cond_i(idle_run), .tick_i(tick_us_i), .hit_o(idle_hit)
  );

  usb_link_fsm u_fsm (
    .clk_i, .rst_ni, .enable_i, .vbus_i,
    .se0_i(line_se0_i), .idle_i(idle),
    .se0_hit_i(se0_hit), .idle_hit_i(idle_hit),
    .state_o(state), .ev_o(ev)
  );

  assign sof_active = live && (state == LINK_ACTIVE);

  usb_link_sof_watch #(.GAP(SOF_GAP_US)) u_sof_watch (
    .clk_i, .rst_ni, .active_i(sof_active), .tick_i(tick_us_i), .sof_i,
    .lost_o(host_lost_o), .lost_ev_o(ev_host_lost_o)
  );

  assign link_state_o    = state;
  assign ev_disconnect_o = ev.disc;
  assign ev_reset_o      = ev.rst;
  assign ev_suspend_o    = ev.susp;
  assign ev_resume_o     = ev.resume;
  assign addr_clr_o      = ev.rst;

  // R2
  disable_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !host_lost_o && !ev_host_lost_o);
  // R5
  addr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_clr_o |-> link_state_o == 2'd1);
endmodule

// File: tb/tb_usb_link_mon.sv
module tb_usb_link_mon;
  localparam int CLK_PERIOD = 10;
  localparam int RST_US = 3;
  localparam int SUS_US = 3000;
  localparam int GAP_US = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, tick = 1, vbus = 0, se0 = 0, j = 0, sof = 0;
  logic [1:0] st;
  logic lost, e_disc, e_rst, e_sus, e_res, e_lost, a_clr;

  int n_chk = 0, n_bad = 0, tick_div = 1, tick_ph = 0;
  int c_disc = 0, c_rst = 0, c_sus = 0, c_res = 0, c_lost = 0, c_clr = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_link_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .tick_us_i(tick),
    .vbus_i(vbus), .line_se0_i(se0), .line_j_i(j), .sof_i(sof),
    .link_state_o(st), .host_lost_o(lost), .ev_disconnect_o(e_disc),
    .ev_reset_o(e_rst), .ev_suspend_o(e_sus), .ev_resume_o(e_res),
    .ev_host_lost_o(e_lost), .addr_clr_o(a_clr)
  );

  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    tick   <= (tick_ph == 0);
  end

  // behavioural reference
  int m_se0, m_j, m_gap, m_st;
  bit m_lost, m_disc, m_rst, m_sus, m_res, m_elost;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_se0 = 0; m_j = 0; m_gap = 0; m_st = 0;
      {m_lost, m_disc, m_rst, m_sus, m_res, m_elost} = '0;
    end else begin
      bit se0c, jc, sh, jh, act;
      int ns;
      se0c = en && vbus && se0;
      jc   = en && vbus && j && !se0;
      sh   = m_se0 > RST_US;
      jh   = m_j > SUS_US;
      act  = en && vbus && m_st == 3;
      if (!se0c) m_se0 = 0; else if (tick && m_se0 <= RST_US) m_se0++;
      if (!jc) m_j = 0; else if (tick && m_j <= SUS_US) m_j++;
      {m_disc, m_rst, m_sus, m_res, m_elost} = '0;
      ns = m_st;
      if (!en) ns = 0;
      else if (!vbus) begin m_disc = (m_st != 0); ns = 0; end
      else if (sh) begin m_rst = (m_st != 1); ns = 1; end
      else if (m_st == 0) ns = 3;
      else if (m_st == 1) begin if (!se0) ns = 3; end
      else if (m_st == 3) begin if (jh) begin ns = 2; m_sus = 1; end end
      else if (!jc) begin ns = 3; m_res = 1; end
      if (sof || !act) begin m_gap = 0; m_lost = 0; end
      else if (tick && m_gap != GAP_US) begin
        m_gap++;
        if (m_gap == GAP_US) begin m_lost = 1; m_elost = 1; end
      end
      m_st = ns;
    end
  end

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!done) begin
      logic [7:0] got, exp;
      got = {st, lost, e_disc, e_rst, e_sus, e_res, e_lost};
      exp = {m_st[1:0], m_lost, m_disc, m_rst, m_sus, m_res, m_elost};
      n_chk++;
      if (got !== exp || a_clr !== m_rst) begin
        n_bad++;
        $display("FAIL %s cycle compare: got=%b clr=%b exp=%b clr=%b", cur_req, got, a_clr, exp, m_rst);
      end
      c_disc += e_disc; c_rst += e_rst; c_sus += e_sus;
      c_res += e_res; c_lost += e_lost; c_clr += a_clr;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got=timeout exp=completion");
    finish_run();
  end

  initial begin
    step(4);
    rst_n = 1;
    step(2);
    cur_req = "R1";
    chk("R1", st, 0);
    chk("R1", lost, 0);

    cur_req = "R2";
    vbus = 1; se0 = 1;
    step(20);
    chk("R2", st, 0);
    chk("R2", c_rst, 0);
    se0 = 0;

    cur_req = "R4";
    en = 1;
    step(2);
    chk("R4", st, 3);

    cur_req = "R6";
    for (int k = 0; k < 2; k++) begin
      se0 = 1; step(3);
      se0 = 0; step(1);
    end
    step(2);
    chk("R6", c_rst, 0);
    chk("R6", st, 3);

    cur_req = "R5";
    se0 = 1; step(12);
    chk("R5", st, 1);
    chk("R5", c_rst, 1);
    chk("R5", c_clr, 1);
    se0 = 0; step(3);
    chk("R5", st, 3);

    cur_req = "R6";
    tick_div = 4;
    se0 = 1; step(10);
    se0 = 0; step(2);
    se0 = 1; step(40);
    chk("R6", c_rst, 2);
    se0 = 0; step(4);
    tick_div = 1;
    step(4);

    cur_req = "R7";
    j = 1;
    for (int k = 0; k < 3100; k++) begin
      sof = (k % 900 == 0);
      step(1);
    end
    sof = 0;
    chk("R7", st, 2);
    chk("R7", c_sus, 1);
    step(200);
    chk("R10", c_sus, 1);

    cur_req = "R8";
    j = 0; step(2);
    chk("R8", st, 3);
    chk("R8", c_res, 1);

    cur_req = "R9";
    step(5000);
    chk("R9", lost, 1);
    chk("R9", c_lost, 1);
    sof = 1; step(1); sof = 0; step(1);
    chk("R9", lost, 0);

    cur_req = "R3";
    vbus = 0; step(3);
    chk("R3", st, 0);
    chk("R3", c_disc, 1);
    step(10);
    chk("R10", c_disc, 1);

    cur_req = "R2";
    vbus = 1; step(3);
    en = 0; se0 = 1; step(10);
    chk("R2", st, 0);
    chk("R2", c_rst, 2);
    chk("R2", c_disc, 1);
    step(2);
    finish_run();
  end
endmodule